// File: doc/BRIEF.md
# Lookup-Table Logic Element with Parallel Parity Gate

This block models one programmable logic element of an FPGA fabric, plus a two-element wrapper that puts it to its intended use. Each element holds a six-input lookup table whose 64-entry truth table is shifted in serially. A six-input exclusive-OR gate sits beside the table. It reads the same six select inputs and needs no pins of its own. Each element therefore yields two functions of its inputs: an arbitrary one from the table and the parity from the gate. Each of the two results also passes through its own output flip-flop, which one configuration bit can bypass.

The wrapper chains the configuration of two elements and feeds both the same six data bits. With suitable truth tables the pair acts as a six-bit population counter. The parity gate of the first element supplies the weight-1 bit. The first table supplies the weight-2 bit and the second table supplies the weight-4 bit. A table-only element would need a third element to form the parity. The second element's parity gate is brought out as a spare output.

Top module: `lxe_counter6`

## Requirements
- R1: In each element the table output equals configuration bit k of that element, where k is the unsigned value of the six data inputs with din[0] as the least significant bit. `cnt_comb[1]` comes from element 0 and `cnt_comb[2]` from element 1.
- R2: The parity output of each element is the XOR of all six data inputs, whatever the table holds. Element 0's parity is `cnt_comb[0]`; element 1's parity drives `aux_xor` through its output stage.
- R3: Each element holds a 66-bit configuration word. Bits 63..0 are the truth table, bit 64 selects the register for the table path and bit 65 selects it for the parity path (1 = registered). At a rising edge with `cfg_shift` high, every word moves up one place. `cfg_din` enters bit 0 of element 0, bit 65 of element 0 enters bit 0 of element 1, and `cfg_dout` shows bit 65 of element 1. A full load is therefore element 1's word followed by element 0's word, each sent bit 65 first.
- R4: While `cfg_shift` is low, the configuration does not change whatever `cfg_din` does.
- R5: An output whose select bit is 1 shows, one clock after a rising edge, the combinational value present at that edge.
- R6: An output whose select bit is 0 follows its combinational value in the same cycle.
- R7: At a rising edge with `rst` high, every output flip-flop clears to 0. The reset leaves the configuration unchanged.
- R8: With the counter tables loaded (table bit k of element 0 = bit 1 of popcount(k), of element 1 = bit 2 of popcount(k)), `cnt_comb` equals the number of ones on `din` for all 64 input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_shift | input | 1 | Shift strobe for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (last bit of the chain) |
| din | input | 6 | Data inputs shared by both tables and both parity gates |
| cnt_comb | output | 3 | Combinational count {e1 table, e0 table, e0 parity} |
| cnt_out | output | 3 | Same three results after each one's select stage |
| aux_xor | output | 1 | Element 1 parity after its select stage |

## Verification
The combinational results (`cnt_comb`, and any output set to bypass) are due in the same cycle as `din`. The bench drives `din` on the falling edge and reads them 1 ns later, before any rising edge. A registered output is due one rising edge later, so the bench reads it at the next falling edge against the input it drove the cycle before. A configuration bit takes effect at the rising edge that shifts it in, so outputs are checked only after the strobe has dropped. A reset takes effect at the first rising edge with `rst` high, and the bench reads the cleared outputs at the following falling edge.

// File: rtl/lxe_pkg.sv
package lxe_pkg;
    parameter int unsigned LE_K = 6;
    localparam int unsigned LE_TT = 1 << LE_K;
    localparam int unsigned LE_CFG_W = LE_TT + 2;
    localparam int unsigned LE_SEL_LUT = LE_TT;
    localparam int unsigned LE_SEL_XOR = LE_TT + 1;
    localparam int unsigned LE_CNT_W = $clog2(LE_K + 1);
    localparam int unsigned LE_N_CELL = 2;

    typedef struct packed {
        logic xr;
        logic lut;
    } le_pair_t;
endpackage

// File: rtl/lxe_cfg_chain.sv
module lxe_cfg_chain #(
    parameter int unsigned W = 66
) (
    input  logic         clk,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (shift) q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/lxe_lut_xor.sv
module lxe_lut_xor #(
    parameter int unsigned K = 6,
    localparam int unsigned TT = 1 << K
) (
    input  logic [TT-1:0] tt,
    input  logic [K-1:0]  x,
    output logic          lut_o,
    output logic          xor_o
);
    always_comb begin
        lut_o = tt[x];
        xor_o = ^x;
    end
endmodule

// File: rtl/lxe_outreg.sv
module lxe_outreg (
    input  logic clk,
    input  logic rst,
    input  logic use_reg,
    input  logic d,
    output logic q
);
    logic ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= 1'b0;
        else     ff <= d;
    end

    assign q = use_reg ? ff : d;
endmodule

// File: rtl/lxe_cell.sv
module lxe_cell
    import lxe_pkg::*;
#(
    parameter int unsigned K = LE_K,
    localparam int unsigned TT = 1 << K,
    localparam int unsigned CW = TT + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_shift,
    input  logic          cfg_sin,
    input  logic [K-1:0]  x,
    output logic [CW-1:0] cfg_q,
    output le_pair_t      comb,
    output le_pair_t      outp
);
    logic       lut_c;
    logic       xor_c;
    logic [1:0] cmb_v;
    logic [1:0] sel_v;
    logic [1:0] out_v;

    lxe_cfg_chain #(.W(CW)) u_cfg (
        .clk  (clk),
        .shift(cfg_shift),
        .sin  (cfg_sin),
        .q    (cfg_q)
    );

    lxe_lut_xor #(.K(K)) u_fn (
        .tt   (cfg_q[TT-1:0]),
        .x    (x),
        .lut_o(lut_c),
        .xor_o(xor_c)
    );

    assign cmb_v = {xor_c, lut_c};
    assign sel_v = cfg_q[CW-1:TT];

    for (genvar g = 0; g < 2; g++) begin : g_path
        lxe_outreg u_reg (
            .clk    (clk),
            .rst    (rst),
            .use_reg(sel_v[g]),
            .d      (cmb_v[g]),
            .q      (out_v[g])
        );
    end

    assign comb = le_pair_t'(cmb_v);
    assign outp = le_pair_t'(out_v);
endmodule

// File: rtl/lxe_counter6.sv
module lxe_counter6
    import lxe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_shift,
    input  logic                cfg_din,
    output logic                cfg_dout,
    input  logic [LE_K-1:0]     din,
    output logic [LE_CNT_W-1:0] cnt_comb,
    output logic [LE_CNT_W-1:0] cnt_out,
    output logic                aux_xor
);
    logic [LE_N_CELL-1:0][LE_CFG_W-1:0] cell_cfg;
    logic [LE_N_CELL:0]                 chain;
    le_pair_t                           cmb [LE_N_CELL];
    le_pair_t                           sel [LE_N_CELL];

    assign chain[0] = cfg_din;

    for (genvar i = 0; i < LE_N_CELL; i++) begin : g_cell
        lxe_cell #(.K(LE_K)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .cfg_shift(cfg_shift),
            .cfg_sin  (chain[i]),
            .x        (din),
            .cfg_q    (cell_cfg[i]),
            .comb     (cmb[i]),
            .outp     (sel[i])
        );
        assign chain[i+1] = cell_cfg[i][LE_CFG_W-1];
    end

    assign cfg_dout = chain[LE_N_CELL];
    assign cnt_comb = {cmb[1].lut, cmb[0].lut, cmb[0].xr};
    assign cnt_out  = {sel[1].lut, sel[0].lut, sel[0].xr};
    assign aux_xor  = sel[1].xr;
endmodule

// File: rtl/lxe_counter6_chk.sv
module lxe_counter6_chk
    import lxe_pkg::*;
(
    input logic                               clk,
    input logic                               rst,
    input logic                               cfg_shift,
    input logic                               cfg_din,
    input logic [LE_K-1:0]                    din,
    input logic [LE_CNT_W-1:0]                cnt_comb,
    input logic [LE_CNT_W-1:0]                cnt_out,
    input logic [LE_N_CELL-1:0][LE_CFG_W-1:0] cell_cfg
);
    AST_LUT_INDEX: assert property (@(posedge clk) disable iff (rst)
        (cnt_comb[1] == cell_cfg[0][din]) && (cnt_comb[2] == cell_cfg[1][din])); // R1

    AST_XOR_PARITY: assert property (@(posedge clk) disable iff (rst)
        cnt_comb[0] == ^din); // R2

    AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> (cell_cfg[0][0] == $past(cfg_din)) &&
                      (cell_cfg[1][0] == $past(cell_cfg[0][LE_CFG_W-1]))); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift |=> $stable(cell_cfg)); // R4

    AST_REG_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cfg_shift && cell_cfg[0][LE_SEL_LUT]) |=> cnt_out[1] == $past(cnt_comb[1])); // R5

    AST_BYPASS_SAME: assert property (@(posedge clk) disable iff (rst)
        !cell_cfg[0][LE_SEL_XOR] |-> cnt_out[0] == cnt_comb[0]); // R6

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && cell_cfg[1][LE_SEL_LUT]) |-> cnt_out[2] == 1'b0); // R7
endmodule

bind lxe_counter6 lxe_counter6_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_shift(cfg_shift),
    .cfg_din  (cfg_din),
    .din      (din),
    .cnt_comb (cnt_comb),
    .cnt_out  (cnt_out),
    .cell_cfg (cell_cfg)
);

// File: tb/lxe_counter6_bench.sv
module lxe_counter6_bench;
    import lxe_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_shift = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [5:0] din = '0;
    logic [2:0] cnt_comb;
    logic [2:0] cnt_out;
    logic       aux_xor;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lxe_counter6 u_lxe_counter6 (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .din(din), .cnt_comb(cnt_comb),
        .cnt_out(cnt_out), .aux_xor(aux_xor)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pop6(input logic [5:0] v);
        return 3'($countones(v));
    endfunction

    function automatic logic [63:0] count_table(input int b);
        logic [63:0] t;
        for (int k = 0; k < 64; k++) t[k] = pop6(6'(k))[b];
        return t;
    endfunction

    task automatic load(input logic [65:0] w1, input logic [65:0] w0);
        for (int i = 65; i >= 0; i--) begin
            @(negedge clk); cfg_shift = 1'b1; cfg_din = w1[i];
        end
        for (int i = 65; i >= 0; i--) begin
            @(negedge clk); cfg_shift = 1'b1; cfg_din = w0[i];
        end
        @(negedge clk); cfg_shift = 1'b0; cfg_din = 1'b0;
    endtask

    task automatic check_tables(input logic [63:0] t0, input logic [63:0] t1, input string req);
        for (int v = 0; v < 64; v++) begin
            @(negedge clk); din = 6'(v); #1;
            check(cnt_comb[1] == t0[v], req, int'(cnt_comb[1]), int'(t0[v]));
            check(cnt_comb[2] == t1[v], req, int'(cnt_comb[2]), int'(t1[v]));
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] c2, c4, t0, t1;
        logic [5:0]  prev;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        c2 = count_table(1);
        c4 = count_table(2);

        // Counter tables, every path registered; loaded while in reset
        load({1'b1, 1'b1, c4}, {1'b1, 1'b1, c2});
        @(negedge clk); din = 6'h3F; #1;
        check(cnt_out == 3'd0, "R7 reset clears registers", int'(cnt_out), 0);
        check(aux_xor == 1'b0, "R7 reset clears spare", int'(aux_xor), 0);
        check(cnt_comb == 3'd6, "R8 count all ones", int'(cnt_comb), 6);
        check(cfg_dout == 1'b1, "R3 chain out", int'(cfg_dout), 1);
        @(negedge clk); rst = 1'b0;
        prev = 6'h3F;
        for (int v = 0; v < 64 + 150; v++) begin
            logic [5:0] nv;
            nv = (v < 64) ? 6'(v) : 6'($urandom);
            @(negedge clk);
            check(cnt_out == pop6(prev), "R5 registered count", int'(cnt_out), int'(pop6(prev)));
            check(aux_xor == ^prev, "R2 spare parity", int'(aux_xor), int'(^prev));
            din = nv; #1;
            check(cnt_comb == pop6(nv), "R8 popcount", int'(cnt_comb), int'(pop6(nv)));
            prev = nv;
        end

        // Mid-run reset: registers clear, configuration survives
        @(negedge clk); rst = 1'b1; din = 6'h2D;
        @(negedge clk); #1;
        check(cnt_out == 3'd0, "R7 mid-run reset", int'(cnt_out), 0);
        check(cnt_comb == pop6(6'h2D), "R7 config kept", int'(cnt_comb), int'(pop6(6'h2D)));
        rst = 1'b0;
        @(negedge clk);
        check(cnt_out == pop6(6'h2D), "R5 after reset", int'(cnt_out), int'(pop6(6'h2D)));

        // Random tables, all paths bypassed
        t0 = {$urandom, $urandom};
        t1 = {$urandom, $urandom};
        load({1'b0, 1'b0, t1}, {1'b0, 1'b0, t0});
        check(cfg_dout == 1'b0, "R3 chain out", int'(cfg_dout), 0);
        for (int v = 0; v < 64; v++) begin
            logic [2:0] e;
            @(negedge clk); din = 6'(v); #1;
            e = {t1[v], t0[v], ^6'(v)};
            check(cnt_comb == e, "R1 table read", int'(cnt_comb), int'(e));
            check(cnt_out == e, "R6 bypass same cycle", int'(cnt_out), int'(e));
            check(aux_xor == ^6'(v), "R6 spare bypass", int'(aux_xor), int'(^6'(v)));
        end

        // Strobe low: cfg_din noise must not alter the configuration
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); cfg_din = 1'($urandom); din = 6'($urandom);
        end
        @(negedge clk); cfg_din = 1'b0;
        check_tables(t0, t1, "R4 config held");

        // Mixed selects: e0 table bypassed, e0 parity and e1 table registered
        load({1'b0, 1'b1, t1}, {1'b1, 1'b0, t0});
        prev = din;
        for (int v = 0; v < 80; v++) begin
            logic [5:0] nv;
            nv = (v == 0) ? 6'h00 : (v == 1) ? 6'h3F : 6'($urandom);
            @(negedge clk);
            check(cnt_out[0] == ^prev, "R5 parity registered", int'(cnt_out[0]), int'(^prev));
            check(cnt_out[2] == t1[prev], "R5 table registered", int'(cnt_out[2]), int'(t1[prev]));
            din = nv; #1;
            check(cnt_out[1] == t0[nv], "R6 table bypassed", int'(cnt_out[1]), int'(t0[nv]));
            check(cnt_comb[0] == ^nv, "R2 parity", int'(cnt_comb[0]), int'(^nv));
            prev = nv;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule